// File: doc/BRIEF.md
# SPI FIFO and Interrupt Controller

This block is the buffering and interrupt layer between a processor's register interface and an SPI serial shift engine. It keeps two byte FIFOs, one for transmit and one for receive, each four entries deep by default. The processor pushes transmit bytes and pops received bytes. The serial engine takes transmit bytes through a valid/take handshake and delivers received bytes as single-cycle strobes.

A two-bit interrupt mode selects the trigger points. The transmit interrupt fires after a chosen number of bytes has left the transmit FIFO. The receive interrupt tracks the receive FIFO fill level against a threshold, and the transmit and receive thresholds differ for the same mode. Each FIFO has a flush control that acts as a level: for as long as it is held, that FIFO is kept empty and all traffic into it is dropped. An overwrite control decides what happens when a byte arrives at a full receive FIFO. A zero-fill control chooses the byte the engine sends when the transmit FIFO has run dry.

Top module: `spi_fifo_irq_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after reset is released, both FIFOs are empty, `tx_irq` and `rx_irq` are low, `eng_tx_valid` and `bus_rx_valid` are low, and `eng_tx_data` is 0x00.
- R2: `eng_tx_valid` is high exactly when the transmit FIFO holds a byte. `eng_tx_data` then shows the oldest byte, and bytes reach the engine in write order. A `bus_tx_wr` into a full FIFO (4 bytes) is dropped unless a take happens in the same cycle.
- R3: `bus_rx_valid` is high exactly when the receive FIFO holds a byte. `bus_rx_data` then shows the oldest byte, and bytes leave in strobe order. A `bus_rx_rd` on an empty FIFO has no effect.
- R4: A take of a valid byte increments a sent-byte counter. The cycle after the take that brings the counter to mode+1 (mode 00→1, 01→2, 10→3, 11→4), `tx_irq` goes high and the counter restarts from zero.
- R5: `tx_irq` stays high until a bus write is accepted into the transmit FIFO or `tx_flush` is high, and it is low from the next cycle. A raise in the same cycle takes priority over the clear.
- R6: `rx_irq` is high while the receive FIFO holds at least N bytes, where N is 1 for mode 00 and 01, 3 for mode 10, and 4 (full) for mode 11.
- R7: While `tx_flush` is high, the transmit FIFO is emptied on every clock, bus writes and engine takes are ignored, and the sent-byte counter and `tx_irq` are cleared.
- R8: While `rx_flush` is high, the receive FIFO is emptied on every clock, strobes and reads are ignored, and `rx_irq` is low.
- R9: A strobe into a full receive FIFO with no read in the same cycle discards the oldest stored byte and appends the new one when `rx_overwrite` is high. When `rx_overwrite` is low, the FIFO is left unchanged and the new byte is lost.
- R10: With the transmit FIFO empty, `eng_tx_data` is 0x00 when `tx_zero_fill` is high. Otherwise it is the last byte the engine took, or 0x00 if no byte has been taken since reset.
- R11: A push and a pop in the same cycle on a full FIFO keep it at 4 bytes and preserve the order: the oldest byte leaves and the new byte becomes the youngest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_mode | input | 2 | Interrupt threshold mode |
| tx_flush | input | 1 | Level: hold transmit FIFO empty and drop its traffic |
| rx_flush | input | 1 | Level: hold receive FIFO empty and drop its traffic |
| rx_overwrite | input | 1 | Full receive FIFO replaces its oldest byte when high |
| tx_zero_fill | input | 1 | Empty transmit FIFO sends 0x00 when high, else repeats the last byte |
| bus_tx_wr | input | 1 | Bus write strobe into the transmit FIFO |
| bus_tx_data | input | 8 | Bus write byte |
| bus_rx_rd | input | 1 | Bus read strobe popping the receive FIFO |
| bus_rx_data | output | 8 | Oldest receive byte |
| bus_rx_valid | output | 1 | Receive FIFO not empty |
| eng_tx_valid | output | 1 | Transmit FIFO holds a byte for the engine |
| eng_tx_data | output | 8 | Byte for the engine to shift out |
| eng_tx_take | input | 1 | Engine has taken the current transmit byte |
| eng_rx_strobe | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| tx_irq | output | 1 | Transmit interrupt level |
| rx_irq | output | 1 | Receive interrupt level |

## Verification
The assertions assume that every input carries a defined 0 or 1 from the first clock after reset, and that `eng_tx_take` and `eng_rx_strobe` each stand for one byte per high cycle. No other handshake discipline is assumed: takes on an empty FIFO, reads of an empty FIFO and writes into a full one are all legal and have defined outcomes. The stimulus drives every input away from the clock edge. It holds the control levels steady over directed phases and changes them only at chosen points in the random phase, and it issues flushes rarely, so that the FIFOs regularly reach the full and threshold states.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

  typedef enum logic [1:0] {
    IRQ_M1 = 2'b00,
    IRQ_M2 = 2'b01,
    IRQ_M3 = 2'b10,
    IRQ_M4 = 2'b11
  } irq_mode_e;

  // Receive fill level at which the receive interrupt is raised.
  function automatic int unsigned rx_need(irq_mode_e m, int unsigned depth);
    case (m)
      IRQ_M1:  return 1;
      IRQ_M2:  return 1;
      IRQ_M3:  return depth - 1;
      default: return depth;
    endcase
  endfunction

  // Number of sent bytes that raises the transmit interrupt.
  function automatic int unsigned tx_need(irq_mode_e m);
    return int'(m) + 1;
  endfunction

endpackage

// File: rtl/spi_rst_sync.sv
module spi_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter  int W     = 8,
  parameter  int DEPTH = 4,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr_q, rd_ptr_nxt, wr_ptr_q, wr_ptr_nxt;
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          full, empty, pop_ok, push_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign pop_ok  = pop & ~empty;
  assign push_ok = push & (~full | pop_ok);

  always_comb begin
    rd_ptr_nxt = rd_ptr_q;
    wr_ptr_nxt = wr_ptr_q;
    cnt_nxt    = cnt_q;
    if (clr) begin
      rd_ptr_nxt = '0;
      wr_ptr_nxt = '0;
      cnt_nxt    = '0;
    end else begin
      if (pop_ok)  rd_ptr_nxt = bump(rd_ptr_q);
      if (push_ok) wr_ptr_nxt = bump(wr_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_nxt = cnt_q + 1'b1;
        2'b01:   cnt_nxt = cnt_q - 1'b1;
        default: cnt_nxt = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      rd_ptr_q <= rd_ptr_nxt;
      wr_ptr_q <= wr_ptr_nxt;
      cnt_q    <= cnt_nxt;
    end
  end

  // Storage carries no reset; only written entries are ever observed.
  always_ff @(posedge clk) begin
    if (push_ok && !clr) mem[wr_ptr_q] <= din;
  end

  assign dout  = mem[rd_ptr_q];
  assign count = cnt_q;

  assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  assert_full_pushpop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && pop && !clr) |=> (cnt_q == CW'(DEPTH)));

  assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

endmodule

// File: rtl/spi_tx_ctrl.sv
module spi_tx_ctrl
  import spi_fifo_pkg::*;
#(
  parameter  int W     = 8,
  parameter  int DEPTH = 4,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode,
  input  logic         flush,
  input  logic         zero_fill,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         take,
  output logic         valid,
  output logic [W-1:0] data,
  output logic         irq
);

  logic [W-1:0]  head, last_q, last_nxt;
  logic [CW-1:0] level, sent_q, sent_nxt, need, inc;
  logic          full, empty, pop, wr_acc, raise, irq_q, irq_nxt;

  spi_byte_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (flush),
    .push  (wr_acc),
    .pop   (pop),
    .din   (wdata),
    .dout  (head),
    .count (level)
  );

  assign full   = (level == CW'(DEPTH));
  assign empty  = (level == '0);
  assign pop    = take & ~flush & ~empty;
  assign wr_acc = wr & ~flush & (~full | pop);
  assign need   = CW'(tx_need(irq_mode_e'(mode)));

  always_comb begin
    inc      = sent_q + 1'b1;
    raise    = 1'b0;
    sent_nxt = sent_q;
    if (flush) begin
      sent_nxt = '0;
    end else if (pop) begin
      if (inc >= need) begin
        raise    = 1'b1;
        sent_nxt = '0;
      end else begin
        sent_nxt = inc;
      end
    end
  end

  always_comb begin
    if (flush)       irq_nxt = 1'b0;
    else if (raise)  irq_nxt = 1'b1;
    else if (wr_acc) irq_nxt = 1'b0;
    else             irq_nxt = irq_q;
  end

  assign last_nxt = head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sent_q <= '0;
      irq_q  <= 1'b0;
      last_q <= '0;
    end else begin
      sent_q <= sent_nxt;
      irq_q  <= irq_nxt;
      if (pop) last_q <= last_nxt;
    end
  end

  assign valid = ~empty;
  assign data  = valid ? head : (zero_fill ? '0 : last_q);
  assign irq   = irq_q;

  assert_flush_drains_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !valid);

  assert_flush_quiets_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !irq);

  assert_irq_follows_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(take && valid && !flush));

  assert_write_clears_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && wr && !flush && !full && !(take && valid)) |=> !irq);

endmodule

// File: rtl/spi_rx_ctrl.sv
module spi_rx_ctrl
  import spi_fifo_pkg::*;
#(
  parameter  int W     = 8,
  parameter  int DEPTH = 4,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode,
  input  logic         flush,
  input  logic         overwrite,
  input  logic         strobe,
  input  logic [W-1:0] sdata,
  input  logic         rd,
  output logic         valid,
  output logic [W-1:0] data,
  output logic         irq
);

  logic [W-1:0]  head;
  logic [CW-1:0] level, need;
  logic          full, empty, rd_ok, evict, pop, push;

  spi_byte_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (flush),
    .push  (push),
    .pop   (pop),
    .din   (sdata),
    .dout  (head),
    .count (level)
  );

  assign full  = (level == CW'(DEPTH));
  assign empty = (level == '0);
  assign rd_ok = rd & ~flush & ~empty;
  // Overflow with overwrite: the oldest byte is dropped to make room.
  assign evict = strobe & ~flush & full & overwrite & ~rd_ok;
  assign pop   = rd_ok | evict;
  assign push  = strobe & ~flush & (~full | pop);
  assign need  = CW'(rx_need(irq_mode_e'(mode), DEPTH));

  assign valid = ~empty;
  assign data  = head;
  assign irq   = ~flush & (level >= need);

  assert_flush_drains_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !valid);

  assert_drop_keeps_head_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (full && strobe && !overwrite && !rd && !flush) |=> (valid && $stable(data)));

  assert_overwrite_stays_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (full && strobe && overwrite && !rd && !flush) |=> full);

  assert_irq_needs_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> valid);

endmodule

// File: rtl/spi_fifo_irq_ctrl.sv
module spi_fifo_irq_ctrl #(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        irq_mode,
  input  logic              tx_flush,
  input  logic              rx_flush,
  input  logic              rx_overwrite,
  input  logic              tx_zero_fill,
  input  logic              bus_tx_wr,
  input  logic [DATA_W-1:0] bus_tx_data,
  input  logic              bus_rx_rd,
  output logic [DATA_W-1:0] bus_rx_data,
  output logic              bus_rx_valid,
  output logic              eng_tx_valid,
  output logic [DATA_W-1:0] eng_tx_data,
  input  logic              eng_tx_take,
  input  logic              eng_rx_strobe,
  input  logic [DATA_W-1:0] eng_rx_data,
  output logic              tx_irq,
  output logic              rx_irq
);

  logic srst_n;

  spi_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  spi_tx_ctrl #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_tx (
    .clk       (clk),
    .rst_n     (srst_n),
    .mode      (irq_mode),
    .flush     (tx_flush),
    .zero_fill (tx_zero_fill),
    .wr        (bus_tx_wr),
    .wdata     (bus_tx_data),
    .take      (eng_tx_take),
    .valid     (eng_tx_valid),
    .data      (eng_tx_data),
    .irq       (tx_irq)
  );

  spi_rx_ctrl #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rx (
    .clk       (clk),
    .rst_n     (srst_n),
    .mode      (irq_mode),
    .flush     (rx_flush),
    .overwrite (rx_overwrite),
    .strobe    (eng_rx_strobe),
    .sdata     (eng_rx_data),
    .rd        (bus_rx_rd),
    .valid     (bus_rx_valid),
    .data      (bus_rx_data),
    .irq       (rx_irq)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(srst_n) |-> (!tx_irq && !rx_irq && !eng_tx_valid && !bus_rx_valid));

endmodule

// File: tb/spi_fifo_irq_ctrl_tb.sv
module spi_fifo_irq_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] irq_mode;
  logic       tx_flush, rx_flush, rx_overwrite, tx_zero_fill;
  logic       bus_tx_wr, bus_rx_rd, eng_tx_take, eng_rx_strobe;
  logic [7:0] bus_tx_data, eng_rx_data;
  logic [7:0] bus_rx_data, eng_tx_data;
  logic       bus_rx_valid, eng_tx_valid, tx_irq, rx_irq;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_fifo_irq_ctrl u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq_mode     (irq_mode),
    .tx_flush     (tx_flush),
    .rx_flush     (rx_flush),
    .rx_overwrite (rx_overwrite),
    .tx_zero_fill (tx_zero_fill),
    .bus_tx_wr    (bus_tx_wr),
    .bus_tx_data  (bus_tx_data),
    .bus_rx_rd    (bus_rx_rd),
    .bus_rx_data  (bus_rx_data),
    .bus_rx_valid (bus_rx_valid),
    .eng_tx_valid (eng_tx_valid),
    .eng_tx_data  (eng_tx_data),
    .eng_tx_take  (eng_tx_take),
    .eng_rx_strobe(eng_rx_strobe),
    .eng_rx_data  (eng_rx_data),
    .tx_irq       (tx_irq),
    .rx_irq       (rx_irq)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  string phase = "R1 reset";

  // Reference state derived from the requirements.
  logic [7:0] tq[$];
  logic [7:0] rq[$];
  int         tcnt = 0;
  bit         tirq = 0;
  logic [7:0] last_sent = 8'h00;

  function automatic int rx_thr(logic [1:0] m);
    case (m)
      2'b00, 2'b01: return 1;
      2'b10:        return 3;
      default:      return 4;
    endcase
  endfunction

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", phase, what, act, exp);
    end
  endtask

  task automatic compare();
    bit         ev;
    logic [7:0] ed;
    ev = (tq.size() > 0);
    ed = ev ? tq[0] : (tx_zero_fill ? 8'h00 : last_sent);
    chk("R2 tx valid", int'(eng_tx_valid), int'(ev));
    chk(ev ? "R2 tx head" : "R10 filler", int'(eng_tx_data), int'(ed));
    chk("R3 rx valid", int'(bus_rx_valid), int'(rq.size() > 0));
    if (rq.size() > 0) chk("R3 rx head", int'(bus_rx_data), int'(rq[0]));
    chk("R4 R5 tx_irq", int'(tx_irq), int'(tirq));
    chk("R6 rx_irq", int'(rx_irq), int'(!rx_flush && rq.size() >= rx_thr(irq_mode)));
  endtask

  task automatic idle_inputs();
    bus_tx_wr = 0; bus_rx_rd = 0; eng_tx_take = 0; eng_rx_strobe = 0;
  endtask

  // One clock: update the reference with the driven inputs, then compare.
  task automatic tick();
    bit pop, acc, raise, rd_ok;
    if (tx_flush) begin
      tq.delete(); tcnt = 0; tirq = 0;
    end else begin
      pop   = eng_tx_take && tq.size() > 0;
      acc   = bus_tx_wr && (tq.size() < DEPTH || pop);
      raise = 0;
      if (pop) begin
        last_sent = tq.pop_front();
        tcnt++;
        if (tcnt >= int'(irq_mode) + 1) begin tcnt = 0; raise = 1; end
      end
      if (acc) tq.push_back(bus_tx_data);
      if (raise) tirq = 1; else if (acc) tirq = 0;
    end
    if (rx_flush) begin
      rq.delete();
    end else begin
      rd_ok = bus_rx_rd && rq.size() > 0;
      if (rd_ok) void'(rq.pop_front());
      if (eng_rx_strobe) begin
        if (rq.size() < DEPTH) rq.push_back(eng_rx_data);
        else if (rx_overwrite) begin void'(rq.pop_front()); rq.push_back(eng_rx_data); end
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic tx_write(logic [7:0] d);
    idle_inputs(); bus_tx_wr = 1; bus_tx_data = d; tick(); idle_inputs();
  endtask

  task automatic tx_take();
    idle_inputs(); eng_tx_take = 1; tick(); idle_inputs();
  endtask

  task automatic rx_push(logic [7:0] d);
    idle_inputs(); eng_rx_strobe = 1; eng_rx_data = d; tick(); idle_inputs();
  endtask

  task automatic rx_read();
    idle_inputs(); bus_rx_rd = 1; tick(); idle_inputs();
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog [all requirements] actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int unsigned r;
    r = $urandom(32'h0000_5eed);
    rst_n = 0;
    irq_mode = 2'b00; tx_flush = 0; rx_flush = 0; rx_overwrite = 0; tx_zero_fill = 0;
    bus_tx_data = 0; eng_rx_data = 0;
    idle_inputs();
    repeat (3) @(negedge clk);
    // R1: outputs quiet while reset is held and right after its release.
    compare();
    chk("R1 tx data", int'(eng_tx_data), 0);
    rst_n = 1;
    repeat (3) tick();
    chk("R1 tx data after release", int'(eng_tx_data), 0);

    phase = "R2 R10 fill and drain";
    for (int i = 0; i < 5; i++) tx_write(8'hA0 + 8'(i));
    for (int i = 0; i < 5; i++) tx_take();
    chk("R10 repeats last", int'(eng_tx_data), 8'hA3);
    tx_zero_fill = 1; tick();
    chk("R10 zero fill", int'(eng_tx_data), 0);
    tx_zero_fill = 0;

    phase = "R4 R5 tx threshold";
    for (int m = 0; m < 4; m++) begin
      irq_mode = 2'(m);
      for (int i = 0; i <= m; i++) tx_write(8'h10 * 8'(m) + 8'(i));
      for (int i = 0; i <= m; i++) tx_take();
      chk("R4 raised after mode+1 takes", int'(tx_irq), 1);
      tick();
      chk("R5 irq held", int'(tx_irq), 1);
      tx_write(8'h5A);
      chk("R5 write clears irq", int'(tx_irq), 0);
      tx_take();
    end

    phase = "R7 tx flush";
    irq_mode = 2'b00;
    tx_write(8'h11); tx_write(8'h22); tx_take();
    tx_flush = 1;
    tx_write(8'h33); tx_write(8'h44); tx_take();
    chk("R7 empty during flush", int'(eng_tx_valid), 0);
    chk("R7 irq cleared", int'(tx_irq), 0);
    tx_flush = 0; tick();

    phase = "R11 tx full push+pop";
    for (int i = 0; i < 4; i++) tx_write(8'hC0 + 8'(i));
    idle_inputs(); bus_tx_wr = 1; bus_tx_data = 8'hC4; eng_tx_take = 1; tick(); idle_inputs();
    for (int i = 0; i < 5; i++) tx_take();

    phase = "R6 R9 rx overflow drop";
    irq_mode = 2'b10; rx_overwrite = 0;
    for (int i = 0; i < 5; i++) rx_push(8'hB0 + 8'(i));
    chk("R9 oldest kept", int'(bus_rx_data), 8'hB0);
    phase = "R9 rx overwrite";
    rx_overwrite = 1; rx_push(8'hB5);
    chk("R9 oldest evicted", int'(bus_rx_data), 8'hB1);
    phase = "R6 R11 rx thresholds";
    for (int m = 0; m < 4; m++) begin irq_mode = 2'(m); tick(); end
    idle_inputs(); eng_rx_strobe = 1; eng_rx_data = 8'hB6; bus_rx_rd = 1; tick(); idle_inputs();
    for (int i = 0; i < 5; i++) rx_read();

    phase = "R8 rx flush";
    irq_mode = 2'b00;
    rx_push(8'h01); rx_push(8'h02);
    rx_flush = 1;
    rx_push(8'h03); rx_read();
    chk("R8 empty during flush", int'(bus_rx_valid), 0);
    chk("R8 irq low", int'(rx_irq), 0);
    rx_flush = 0; tick();

    phase = "R2 R3 R9 random";
    for (int c = 0; c < 4000; c++) begin
      if (c % 64 == 0) begin
        irq_mode     = 2'($urandom_range(0, 3));
        rx_overwrite = 1'($urandom_range(0, 1));
        tx_zero_fill = 1'($urandom_range(0, 1));
      end
      tx_flush      = ($urandom_range(0, 39) == 0);
      rx_flush      = ($urandom_range(0, 39) == 0);
      bus_tx_wr     = ($urandom_range(0, 99) < 45);
      bus_tx_data   = 8'($urandom);
      eng_tx_take   = ($urandom_range(0, 99) < 40);
      eng_rx_strobe = ($urandom_range(0, 99) < 45);
      eng_rx_data   = 8'($urandom);
      bus_rx_rd     = ($urandom_range(0, 99) < 40);
      tick();
    end
    finish_run();
  end

endmodule